// File: doc/BRIEF.md
# Two-Pass Message Cache Streamer

This block feeds message data to a hash engine, one 512-bit beat at a time, from an external memory reached through a simple beat-read port. A start command gives the message length N in bytes and a mode. In verification mode the message is streamed once. In signing mode it is streamed twice. During the first pass, beats that fall inside the first 4096 bytes are copied into a local beat-wide cache. On the second pass those beats come from the cache with no external request. External reads resume at beat 64, the beat that holds byte 4096.

Each delivered beat carries a byte count. Bytes of the final beat that lie past N are forced to zero. The last beat of each pass is flagged, and a pass bit tells the hash engine which pass it is seeing. Two counters record external traffic. The first counts logical message bytes fetched from outside. The second counts physical beats, where a partial final line still counts as a whole beat. A one-cycle done pulse closes the command.

Top module: `msgc_stream_top`

## Requirements
- R1: After reset, out_valid_o, ext_req_valid_o and done_o are low and both traffic counters read zero.
- R2: In verification mode (sign_mode_i=0) the message is delivered in a single pass. Beats 0 to ceil(N/64)-1 are requested in ascending order, and each beat is delivered with out_pass_o=0 carrying the external data for that beat index.
- R3: In signing mode (sign_mode_i=1) the whole message is delivered twice. The first pass has out_pass_o=0 and the second has out_pass_o=1, and the second pass carries the same beat contents as the first.
- R4: On the second pass, beats with index below 64 (bytes 0 to 4095) are delivered without any external request. External requests on that pass start at beat index 64 and go up in order.
- R5: out_nbytes_o is 64 on every beat except the final beat of a pass, where it is N minus 64 times that beat's index (1 to 64). Bytes at lane positions at or above out_nbytes_o (lane i is out_data_o[8i+7:8i]) are zero. out_last_o is high only on the final beat of each pass.
- R6: After completion, ext_byte_cnt_o equals N in verification mode and N + max(N-4096, 0) in signing mode.
- R7: After completion, ext_beat_cnt_o equals B = ceil(N/64) in verification mode and B + max(B-64, 0) in signing mode.
- R8: While out_valid_o is high and out_ready_i is low, the presented beat, byte count and last flag stay unchanged. A raised ext_req_valid_o holds its beat index until ext_req_ready_i is high. Each beat is requested exactly once per pass.
- R9: done_o pulses for exactly one cycle, in the cycle after the final beat of the final pass is accepted. From then until the next accepted start, both counters hold their values. An accepted start clears both counters.
- R10: A start_i pulse arriving while a command is in progress is ignored and does not alter the running command.
- R11: A start with N=0 produces no request and no beat, pulses done_o in the following cycle, and leaves both counters at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a command (taken only when idle) |
| sign_mode_i | input | 1 | 1 = two passes (signing), 0 = one pass (verification) |
| len_i | input | LEN_W | Message length N in bytes |
| ext_req_valid_o | output | 1 | External beat read request |
| ext_req_beat_o | output | LEN_W-6 | Beat index of the request (byte address / 64) |
| ext_req_ready_i | input | 1 | Request accepted |
| ext_rsp_valid_i | input | 1 | Read data valid |
| ext_rsp_data_i | input | 512 | Read beat, byte 0 in bits 7:0 |
| out_valid_o | output | 1 | Downstream beat valid |
| out_data_o | output | 512 | Downstream beat, unused lanes zero |
| out_nbytes_o | output | 7 | Valid bytes in the beat (1 to 64) |
| out_last_o | output | 1 | Final beat of the current pass |
| out_pass_o | output | 1 | 0 = first pass, 1 = second pass |
| out_ready_i | input | 1 | Downstream accepts the beat |
| done_o | output | 1 | One-cycle completion pulse |
| ext_byte_cnt_o | output | LEN_W+1 | Logical bytes fetched externally |
| ext_beat_cnt_o | output | LEN_W+1 | Physical beats fetched externally |

## Verification
Lengths are chosen around the 64-byte and 4096-byte edges: 1, 64 and 100 bytes in verification mode, and 200, 4096, 4097 and 5000 bytes in signing mode, with a verification run of 4097 bytes as a contrast. A 4096-byte signing run must issue no request on its second pass. A 4097-byte run needs exactly one more request, and that request must be beat 64, which exposes any off-by-one in the cache boundary or in the tail-byte masking. Runs with random downstream and request stalls, set against stall-free runs, show whether a beat is duplicated or dropped under backpressure. A stray start during a run and a zero-length command cover the idle-only acceptance and the empty case.

// File: rtl/msgc_pkg.sv
package msgc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_REQ   = 3'd2,
        ST_WAIT  = 3'd3,
        ST_SEND  = 3'd4
    } msgc_state_e;

endpackage

// File: rtl/msgc_cache.sv
module msgc_cache #(
    parameter int DEPTH  = 64,
    parameter int WIDTH  = 512,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [WIDTH-1:0]  wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [WIDTH-1:0]  rdata_o
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/msgc_lane_mask.sv
module msgc_lane_mask #(
    parameter int BYTES = 64,
    localparam int NB_W = $clog2(BYTES) + 1
) (
    input  logic [BYTES*8-1:0] data_i,
    input  logic [NB_W-1:0]    nbytes_i,
    output logic [BYTES*8-1:0] data_o
);

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign data_o[g*8 +: 8] = (NB_W'(g) < nbytes_i) ? data_i[g*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/msgc_traffic_cnt.sv
module msgc_traffic_cnt #(
    parameter int CNT_W = 21,
    parameter int NB_W  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic [NB_W-1:0]  nbytes_i,
    output logic [CNT_W-1:0] bytes_o,
    output logic [CNT_W-1:0] beats_o
);

    typedef struct packed {
        logic [CNT_W-1:0] bytes;
        logic [CNT_W-1:0] beats;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i) begin
            cnt_d.bytes = cnt_q.bytes + CNT_W'(nbytes_i);
            cnt_d.beats = cnt_q.beats + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign bytes_o = cnt_q.bytes;
    assign beats_o = cnt_q.beats;

endmodule

// File: rtl/msgc_stream_top.sv
module msgc_stream_top
    import msgc_pkg::*;
#(
    parameter int BEAT_BYTES  = 64,
    parameter int CACHE_BYTES = 4096,
    parameter int LEN_W       = 20,
    localparam int DATA_W      = BEAT_BYTES * 8,
    localparam int BYTE_SH     = $clog2(BEAT_BYTES),
    localparam int BEAT_W      = LEN_W - BYTE_SH,
    localparam int NB_W        = BYTE_SH + 1,
    localparam int CNT_W       = LEN_W + 1,
    localparam int CACHE_BEATS = CACHE_BYTES / BEAT_BYTES,
    localparam int CA_W        = $clog2(CACHE_BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sign_mode_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              ext_req_valid_o,
    output logic [BEAT_W-1:0] ext_req_beat_o,
    input  logic              ext_req_ready_i,
    input  logic              ext_rsp_valid_i,
    input  logic [DATA_W-1:0] ext_rsp_data_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_data_o,
    output logic [NB_W-1:0]   out_nbytes_o,
    output logic              out_last_o,
    output logic              out_pass_o,
    input  logic              out_ready_i,
    output logic              done_o,
    output logic [CNT_W-1:0]  ext_byte_cnt_o,
    output logic [CNT_W-1:0]  ext_beat_cnt_o
);

    typedef struct packed {
        msgc_state_e       st;
        logic              sign;
        logic              pass2;
        logic [LEN_W-1:0]  len;
        logic [BEAT_W-1:0] beat;
        logic [BEAT_W-1:0] last_beat;
        logic [DATA_W-1:0] hold;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              is_last;
    logic              in_cache_range;
    logic              from_cache;
    logic [LEN_W-1:0]  rem_bytes;
    logic [NB_W-1:0]   cur_nbytes;
    logic [DATA_W-1:0] cache_rdata;
    logic [DATA_W-1:0] raw_beat;
    logic [DATA_W-1:0] masked_beat;
    logic              cache_we;
    logic              cnt_clr;
    logic              cnt_inc;
    logic              busy;

    // Beat geometry for the beat currently in flight
    assign is_last        = (ctl_q.beat == ctl_q.last_beat);
    assign rem_bytes      = ctl_q.len - LEN_W'({ctl_q.beat, {BYTE_SH{1'b0}}});
    assign cur_nbytes     = is_last ? NB_W'(rem_bytes) : NB_W'(BEAT_BYTES);
    assign in_cache_range = (ctl_q.beat < BEAT_W'(CACHE_BEATS));
    assign from_cache     = ctl_q.pass2 && in_cache_range;
    assign raw_beat       = (ctl_q.st == ST_FETCH) ? cache_rdata : ext_rsp_data_i;
    assign busy           = (ctl_q.st != ST_IDLE);

    msgc_cache #(
        .DEPTH (CACHE_BEATS),
        .WIDTH (DATA_W)
    ) u_cache (
        .clk     (clk),
        .we_i    (cache_we),
        .waddr_i (ctl_q.beat[CA_W-1:0]),
        .wdata_i (masked_beat),
        .raddr_i (ctl_q.beat[CA_W-1:0]),
        .rdata_o (cache_rdata)
    );

    msgc_lane_mask #(
        .BYTES (BEAT_BYTES)
    ) u_mask (
        .data_i   (raw_beat),
        .nbytes_i (cur_nbytes),
        .data_o   (masked_beat)
    );

    msgc_traffic_cnt #(
        .CNT_W (CNT_W),
        .NB_W  (NB_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (cnt_clr),
        .inc_i    (cnt_inc),
        .nbytes_i (cur_nbytes),
        .bytes_o  (ext_byte_cnt_o),
        .beats_o  (ext_beat_cnt_o)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        cache_we   = 1'b0;
        cnt_clr    = 1'b0;
        cnt_inc    = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.sign      = sign_mode_i;
                    ctl_d.pass2     = 1'b0;
                    ctl_d.len       = len_i;
                    ctl_d.beat      = '0;
                    ctl_d.last_beat = BEAT_W'((len_i - LEN_W'(1)) >> BYTE_SH);
                    cnt_clr         = 1'b1;
                    if (len_i == '0) begin
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.st = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (from_cache) begin
                    ctl_d.hold = masked_beat;
                    ctl_d.st   = ST_SEND;
                end else begin
                    ctl_d.st = ST_REQ;
                end
            end
            ST_REQ: begin
                if (ext_req_ready_i) begin
                    ctl_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (ext_rsp_valid_i) begin
                    ctl_d.hold = masked_beat;
                    ctl_d.st   = ST_SEND;
                    cnt_inc    = 1'b1;
                    cache_we   = !ctl_q.pass2 && in_cache_range;
                end
            end
            ST_SEND: begin
                if (out_ready_i) begin
                    if (!is_last) begin
                        ctl_d.beat = ctl_q.beat + BEAT_W'(1);
                        ctl_d.st   = ST_FETCH;
                    end else if (ctl_q.sign && !ctl_q.pass2) begin
                        ctl_d.pass2 = 1'b1;
                        ctl_d.beat  = '0;
                        ctl_d.st    = ST_FETCH;
                    end else begin
                        ctl_d.done = 1'b1;
                        ctl_d.st   = ST_IDLE;
                    end
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ext_req_valid_o = (ctl_q.st == ST_REQ);
    assign ext_req_beat_o  = ctl_q.beat;
    assign out_valid_o     = (ctl_q.st == ST_SEND);
    assign out_data_o      = ctl_q.hold;
    assign out_nbytes_o    = cur_nbytes;
    assign out_last_o      = is_last;
    assign out_pass_o      = ctl_q.pass2;
    assign done_o          = ctl_q.done;

endmodule

// File: rtl/msgc_stream_chk.sv
module msgc_stream_chk #(
    parameter int BEAT_BYTES  = 64,
    parameter int CACHE_BYTES = 4096,
    parameter int LEN_W       = 20,
    localparam int DATA_W      = BEAT_BYTES * 8,
    localparam int BYTE_SH     = $clog2(BEAT_BYTES),
    localparam int BEAT_W      = LEN_W - BYTE_SH,
    localparam int NB_W        = BYTE_SH + 1,
    localparam int CNT_W       = LEN_W + 1,
    localparam int CACHE_BEATS = CACHE_BYTES / BEAT_BYTES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_i,
    input logic              ext_req_valid_o,
    input logic [BEAT_W-1:0] ext_req_beat_o,
    input logic              ext_req_ready_i,
    input logic              out_valid_o,
    input logic [DATA_W-1:0] out_data_o,
    input logic [NB_W-1:0]   out_nbytes_o,
    input logic              out_last_o,
    input logic              out_pass_o,
    input logic              out_ready_i,
    input logic              done_o,
    input logic [CNT_W-1:0]  ext_byte_cnt_o,
    input logic [CNT_W-1:0]  ext_beat_cnt_o
);

    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=>
            (out_valid_o && $stable(out_data_o) && $stable(out_nbytes_o) && $stable(out_last_o)));

    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req_valid_o && !ext_req_ready_i) |=> (ext_req_valid_o && $stable(ext_req_beat_o)));

    p_cache_no_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req_valid_o && out_pass_o) |-> (ext_req_beat_o >= BEAT_W'(CACHE_BEATS)));

    p_tail_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> ((out_nbytes_o != '0) && (out_nbytes_o <= NB_W'(BEAT_BYTES))
                         && ((out_data_o >> (32'(out_nbytes_o) * 8)) == '0)));

    p_full_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_last_o) |-> (out_nbytes_o == NB_W'(BEAT_BYTES)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_cnt_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && !start_i) |=> ($stable(ext_byte_cnt_o) && $stable(ext_beat_cnt_o)));

endmodule

bind msgc_stream_top msgc_stream_chk #(
    .BEAT_BYTES  (BEAT_BYTES),
    .CACHE_BYTES (CACHE_BYTES),
    .LEN_W       (LEN_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .busy_i          (busy),
    .ext_req_valid_o (ext_req_valid_o),
    .ext_req_beat_o  (ext_req_beat_o),
    .ext_req_ready_i (ext_req_ready_i),
    .out_valid_o     (out_valid_o),
    .out_data_o      (out_data_o),
    .out_nbytes_o    (out_nbytes_o),
    .out_last_o      (out_last_o),
    .out_pass_o      (out_pass_o),
    .out_ready_i     (out_ready_i),
    .done_o          (done_o),
    .ext_byte_cnt_o  (ext_byte_cnt_o),
    .ext_beat_cnt_o  (ext_beat_cnt_o)
);

// File: tb/msgc_stream_top_tb.sv
module msgc_stream_top_tb;

    localparam int BB  = 64;
    localparam int LW  = 20;
    localparam int DW  = BB * 8;
    localparam int BW  = LW - 6;
    localparam int NBW = 7;
    localparam int CW  = LW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          sign_mode_i = 1'b0;
    logic [LW-1:0] len_i = '0;
    logic          ext_req_valid_o;
    logic [BW-1:0] ext_req_beat_o;
    logic          ext_req_ready_i = 1'b0;
    logic          ext_rsp_valid_i = 1'b0;
    logic [DW-1:0] ext_rsp_data_i = '0;
    logic          out_valid_o;
    logic [DW-1:0] out_data_o;
    logic [NBW-1:0] out_nbytes_o;
    logic          out_last_o;
    logic          out_pass_o;
    logic          out_ready_i = 1'b0;
    logic          done_o;
    logic [CW-1:0] ext_byte_cnt_o;
    logic [CW-1:0] ext_beat_cnt_o;

    always #4 clk = ~clk;

    msgc_stream_top u_dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .sign_mode_i (sign_mode_i), .len_i (len_i),
        .ext_req_valid_o (ext_req_valid_o), .ext_req_beat_o (ext_req_beat_o),
        .ext_req_ready_i (ext_req_ready_i), .ext_rsp_valid_i (ext_rsp_valid_i),
        .ext_rsp_data_i (ext_rsp_data_i), .out_valid_o (out_valid_o), .out_data_o (out_data_o),
        .out_nbytes_o (out_nbytes_o), .out_last_o (out_last_o), .out_pass_o (out_pass_o),
        .out_ready_i (out_ready_i), .done_o (done_o), .ext_byte_cnt_o (ext_byte_cnt_o),
        .ext_beat_cnt_o (ext_beat_cnt_o)
    );

    typedef struct {
        logic [DW-1:0] data;
        int            nb;
        bit            last;
        bit            pass;
    } beat_t;

    beat_t eq[$];
    int    rq[$];
    int    n_checks = 0;
    int    n_fail = 0;
    int    exp_bytes = 0;
    int    exp_beats = 0;
    int    mseed = 0;
    bit    model_busy = 1'b0;
    bit    done_exp = 1'b0;
    bit    stall_en = 1'b0;
    bit    running = 1'b0;
    int    pend_addr = -1;
    int    pend_lat = 0;
    logic [15:0] lf = 16'hACE1;

    task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mem_beat(int b);
        logic [DW-1:0] r;
        for (int i = 0; i < BB; i++) begin
            int a = b * BB + i;
            r[i*8 +: 8] = 8'(a * 13 + (a >> 7) + mseed + 1);
        end
        return r;
    endfunction

    task automatic build(int n, bit sign);
        int nbeats = (n + BB - 1) / BB;
        eq.delete();
        rq.delete();
        for (int p = 0; p < (sign ? 2 : 1); p++) begin
            for (int b = 0; b < nbeats; b++) begin
                beat_t e;
                logic [DW-1:0] raw = mem_beat(b);
                e.nb   = (b == nbeats - 1) ? n - b * BB : BB;
                e.data = '0;
                for (int i = 0; i < e.nb; i++) e.data[i*8 +: 8] = raw[i*8 +: 8];
                e.last = (b == nbeats - 1);
                e.pass = (p == 1);
                eq.push_back(e);
                if (p == 0 || b >= 64) rq.push_back(b);
            end
        end
        exp_bytes = n + ((sign && n > 4096) ? n - 4096 : 0);
        exp_beats = nbeats + ((sign && nbeats > 64) ? nbeats - 64 : 0);
    endtask

    // Per-cycle driver and reference comparison
    always @(negedge clk) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        out_ready_i     = stall_en ? (lf[1:0] != 2'b00) : 1'b1;
        ext_req_ready_i = stall_en ? (lf[3:2] != 2'b00) : 1'b1;
        ext_rsp_valid_i = 1'b0;
        if (pend_addr >= 0) begin
            if (pend_lat == 0) begin
                ext_rsp_valid_i = 1'b1;
                ext_rsp_data_i  = mem_beat(pend_addr);
                pend_addr       = -1;
            end else begin
                pend_lat--;
            end
        end
        #1;
        if (running) begin
            chk(done_o == done_exp, "R9", "done pulse", DW'(done_o), DW'(done_exp));
            if (done_o) begin
                chk(ext_byte_cnt_o == CW'(exp_bytes), "R6", "byte counter", DW'(ext_byte_cnt_o), DW'(exp_bytes));
                chk(ext_beat_cnt_o == CW'(exp_beats), "R7", "beat counter", DW'(ext_beat_cnt_o), DW'(exp_beats));
            end
            done_exp = 1'b0;
            if (!model_busy) begin
                chk(!out_valid_o && !ext_req_valid_o, "R1", "quiet while idle",
                    DW'({out_valid_o, ext_req_valid_o}), '0);
            end
            if (ext_req_valid_o) begin
                if (rq.size() == 0) begin
                    chk(1'b0, "R4", "unexpected request", DW'(ext_req_beat_o), '1);
                end else begin
                    chk(ext_req_beat_o == BW'(rq[0]), "R4", "request beat", DW'(ext_req_beat_o), DW'(rq[0]));
                    if (ext_req_ready_i) begin
                        pend_addr = int'(ext_req_beat_o);
                        pend_lat  = int'(lf[5:4]);
                        void'(rq.pop_front());
                    end
                end
            end
            if (out_valid_o) begin
                if (eq.size() == 0) begin
                    chk(1'b0, "R2", "unexpected beat", out_data_o, '0);
                end else begin
                    chk(out_data_o == eq[0].data, "R2", "beat data", out_data_o, eq[0].data);
                    chk(out_nbytes_o == NBW'(eq[0].nb), "R5", "byte count", DW'(out_nbytes_o), DW'(eq[0].nb));
                    chk(out_last_o == eq[0].last, "R5", "last flag", DW'(out_last_o), DW'(eq[0].last));
                    chk(out_pass_o == eq[0].pass, "R3", "pass flag", DW'(out_pass_o), DW'(eq[0].pass));
                    if (out_ready_i) begin
                        void'(eq.pop_front());
                        if (eq.size() == 0) begin
                            done_exp   = 1'b1;
                            model_busy = 1'b0;
                            chk(rq.size() == 0, "R4", "requests left over", DW'(rq.size()), '0);
                        end
                    end
                end
            end
            if (start_i && !model_busy) begin
                if (len_i == '0) done_exp = 1'b1;
                else model_busy = 1'b1;
            end
        end
    end

    task automatic run(int n, bit sign, bit stall, int intrude);
        build(n, sign);
        stall_en = stall;
        mseed    = mseed + 17;
        build(n, sign);
        @(negedge clk);
        start_i = 1'b1; sign_mode_i = sign; len_i = LW'(n);
        @(negedge clk);
        start_i = 1'b0;
        if (intrude > 0) begin
            repeat (intrude) @(negedge clk);
            start_i = 1'b1; sign_mode_i = ~sign; len_i = LW'(7);
            @(negedge clk);
            start_i = 1'b0; // R10: must be ignored
        end
        while (model_busy) @(negedge clk);
        repeat (5) @(negedge clk);
        #2;
        chk(ext_byte_cnt_o == CW'(exp_bytes), "R9", "byte counter stable", DW'(ext_byte_cnt_o), DW'(exp_bytes));
        chk(ext_beat_cnt_o == CW'(exp_beats), "R9", "beat counter stable", DW'(ext_beat_cnt_o), DW'(exp_beats));
        chk(eq.size() == 0, "R10", "beats outstanding", DW'(eq.size()), '0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk(!out_valid_o && !ext_req_valid_o && !done_o, "R1", "reset outputs",
            DW'({out_valid_o, ext_req_valid_o, done_o}), '0);
        chk(ext_byte_cnt_o == '0 && ext_beat_cnt_o == '0, "R1", "reset counters",
            DW'({ext_byte_cnt_o, ext_beat_cnt_o}), '0);
        running = 1'b1;
        run(100,  1'b0, 1'b0, 0);   // R2 one pass, partial tail
        run(64,   1'b0, 1'b1, 0);   // R5 exact single beat
        run(1,    1'b0, 1'b0, 0);   // R5 one-byte message
        run(200,  1'b1, 1'b1, 0);   // R3 short two-pass
        run(4096, 1'b1, 1'b0, 0);   // R4 whole second pass cached
        run(4097, 1'b1, 1'b1, 0);   // R4 one byte past the cache
        run(5000, 1'b1, 1'b1, 30);  // R6 R7 R8 R10
        run(4097, 1'b0, 1'b0, 0);   // R6 verify mode past cache size
        run(130,  1'b1, 1'b0, 12);  // R10 stray start
        // R11: empty message
        build(0, 1'b1);
        @(negedge clk);
        start_i = 1'b1; sign_mode_i = 1'b1; len_i = '0;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        #2;
        chk(ext_byte_cnt_o == '0 && ext_beat_cnt_o == '0, "R11", "empty counters",
            DW'({ext_byte_cnt_o, ext_beat_cnt_o}), '0);
        chk(!model_busy, "R11", "empty command busy", DW'(model_busy), '0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule